// File: doc/BRIEF.md
# LIN-Capable Asynchronous Serial Channel

This block is a full-duplex asynchronous serial channel for byte traffic. It can run as a plain UART link or as the link layer of a LIN node. Each direction has two buffer stages. The transmitter has a holding register in front of its shift register, so the next byte can be written while the current one is still shifting out. The receiver has a result buffer behind its shift register, so a finished byte waits there while the next one arrives.

Bit timing comes from a reload counter that produces one oversampling tick for every `cfg_reload + 1` system clocks. Each bit lasts 16 ticks. Configuration can swap the counter for an external oversampling clock.

In LIN operation the transmitter can send a break of programmable length (13 to 16 bits low), followed by a delimiter of 1 to 4 bits high. A receiver set to the slave role reports a break when the line stays low for at least 11 bits. The receiver also flags parity, framing and overrun errors. Each flag stays set until software clears it with a write-one-to-clear strobe.

Top module: `lin_uart_top`

## Requirements
- R1: The transmit holding register takes `tx_wdata` on a `tx_wr` pulse only while `tx_hold_full` is 0. A write that arrives while it is 1 is ignored. The held byte moves to the shifter at the next tick once the line is idle or the previous frame ends, and `tx_hold_full` then drops.
- R2: The frame format is:
  - one start bit of 0;
  - 8 data bits, least significant bit first;
  - an optional parity bit;
  - one stop bit of 1.
  The idle line is 1. A received byte appears on `rx_rdata` with `rx_valid` at 1, and stays there until a `rx_rd` pulse.
- R3: With `cfg_ext_sel` at 0, one bit lasts exactly 16 × (`cfg_reload` + 1) clocks. With `cfg_ext_sel` at 1, each rising edge of `ext_sclk` is one tick, so one bit lasts 16 `ext_sclk` periods.
- R4: A byte that completes while `rx_valid` is 1 and no `rx_rd` is present is discarded. `rx_rdata` keeps the old byte and `err_overrun` is set.
- R5: With `cfg_par_en` at 1, the parity bit is the XOR of the 8 data bits, inverted when `cfg_par_odd` is 1. A received parity bit that differs from this sets `err_parity`, and the byte is still stored.
- R6: A stop bit sampled as 0 sets `err_frame`, and the byte is still stored.
- R7: A `tx_brk_req` pulse makes the transmitter drive `txd` low for exactly (13 + `cfg_brk_ext`) bit times.
- R8: After the break, `txd` is high for exactly (1 + `cfg_dlm_ext`) bit times. A byte waiting in the holding register then starts at once. A pending break takes precedence over a waiting byte.
- R9: The receiver samples each bit at ticks 7, 8 and 9 of its 16 and takes the majority. A start bit whose majority is 1 is rejected, and it produces no byte and no error.
- R10: With `cfg_slave` at 1, `brk_seen` is set once `rxd` has been low for 11 consecutive bit times (176 ticks). With `cfg_slave` at 0 it is never set.
- R11: The flags are cleared by `flag_clr`, one bit per flag:
  - bit0 clears `err_parity`;
  - bit1 clears `err_frame`;
  - bit2 clears `err_overrun`;
  - bit3 clears `brk_seen`.
  A flag being set in the same cycle wins over its clear.
- R12: After synchronous reset:
  - `txd` is 1;
  - `tx_hold_full`, `tx_busy` and `rx_valid` are 0;
  - all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reload | input | RLD_W | Baud counter reload value |
| cfg_ext_sel | input | 1 | Use external oversampling clock |
| ext_sclk | input | 1 | External oversampling clock |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_slave | input | 1 | Slave role, enables break detection |
| cfg_brk_ext | input | 2 | Break length beyond 13 bits |
| cfg_dlm_ext | input | 2 | Delimiter length beyond 1 bit |
| tx_wr | input | 1 | Write strobe for holding register |
| tx_wdata | input | 8 | Byte to transmit |
| tx_brk_req | input | 1 | Request a break and delimiter |
| tx_hold_full | output | 1 | Holding register occupied |
| tx_busy | output | 1 | Transmitter is shifting or sending a break |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop strobe for the receive buffer |
| rx_rdata | output | 8 | Received byte |
| rx_valid | output | 1 | Receive buffer holds a byte |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| brk_seen | output | 1 | Break detected flag |

## Verification
A wrong tick counter or bit counter inside the transmitter shows at once on `txd`. The start bit, the break or the delimiter is then a few clocks too long or too short, and the bench catches this by counting clocks edge to edge. A receiver that tracks the bit phase wrongly gives a wrong byte or a spurious error flag when the stop bit is decided, within one frame of the fault. Buffer-state faults, such as a lost full bit, an overwritten holding byte or a missed overrun, appear at the next write or the next completed byte.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;

    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);
    localparam int DATA_W   = 8;
    localparam int BRK_BITS = 11;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FRAME,
        TX_BRK,
        TX_DLM
    } tx_state_e;

    typedef struct packed {
        logic brk;
        logic ovr;
        logic frm;
        logic par;
    } flag_vec_t;

    function automatic logic calc_par(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
    parameter int RLD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RLD_W-1:0] reload,
    input  logic             ext_sel,
    input  logic             ext_clk,
    output logic             tick
);
    logic [RLD_W-1:0] cnt_q;
    logic [2:0]       ext_sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            ext_sync_q <= '0;
        end else begin
            ext_sync_q <= {ext_sync_q[1:0], ext_clk};
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = ext_sel ? (ext_sync_q[1] & ~ext_sync_q[2]) : (cnt_q == '0);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel && tick && reload != '0) |=> (ext_sel || !tick)); // R3

endmodule

// File: rtl/lin_tx.sv
module lin_tx
    import lin_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        brk_ext,
    input  logic [1:0]        dlm_ext,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              brk_req,
    output logic              hold_full,
    output logic              busy,
    output logic              txd
);
    localparam int SHF_W = DATA_W + 3;

    tx_state_e         state_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic              brk_pend_q;
    logic [SHF_W-1:0]  shf_q;
    logic [OVS_W-1:0]  sub_q;
    logic [4:0]        bits_q;
    logic [4:0]        limit;
    logic              bit_end, done, can_start, start_brk, start_frm;
    logic [SHF_W-1:0]  shf_load;

    always_comb begin
        case (state_q)
            TX_FRAME: limit = par_en ? 5'd11 : 5'd10;
            TX_BRK:   limit = 5'd13 + {3'b000, brk_ext};
            TX_DLM:   limit = 5'd1 + {3'b000, dlm_ext};
            default:  limit = 5'd1;
        endcase
    end

    assign bit_end   = tick && (state_q != TX_IDLE) && (sub_q == OVS_W'(OVS - 1));
    assign done      = bit_end && (bits_q == limit - 5'd1);
    assign can_start = tick && ((state_q == TX_IDLE) || (done && state_q != TX_BRK));
    assign start_brk = can_start && brk_pend_q;
    assign start_frm = can_start && !brk_pend_q && hold_full_q;
    assign shf_load  = par_en ? {1'b1, calc_par(hold_q, par_odd), hold_q, 1'b0}
                              : {2'b11, hold_q, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TX_IDLE;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            brk_pend_q  <= 1'b0;
            shf_q       <= '1;
            sub_q       <= '0;
            bits_q      <= '0;
        end else begin
            if (tick && state_q != TX_IDLE) sub_q <= sub_q + 1'b1;
            if (start_brk) begin
                state_q    <= TX_BRK;
                brk_pend_q <= 1'b0;
                bits_q     <= '0;
                sub_q      <= '0;
            end else if (start_frm) begin
                state_q     <= TX_FRAME;
                shf_q       <= shf_load;
                hold_full_q <= 1'b0;
                bits_q      <= '0;
                sub_q       <= '0;
            end else if (done) begin
                bits_q  <= '0;
                state_q <= (state_q == TX_BRK) ? TX_DLM : TX_IDLE;
            end else if (bit_end) begin
                bits_q <= bits_q + 1'b1;
                if (state_q == TX_FRAME) shf_q <= {1'b1, shf_q[SHF_W-1:1]};
            end
            if (wr && !hold_full_q) begin
                hold_q      <= wdata;
                hold_full_q <= 1'b1;
            end
            if (brk_req) brk_pend_q <= 1'b1;
        end
    end

    always_comb begin
        case (state_q)
            TX_FRAME: txd = shf_q[0];
            TX_BRK:   txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    assign hold_full = hold_full_q;
    assign busy      = (state_q != TX_IDLE);

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (hold_full_q && !start_frm) |=> (hold_full_q && $stable(hold_q))); // R1
    AST_BRK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (can_start && brk_pend_q) |=> (state_q == TX_BRK)); // R8

endmodule

// File: rtl/lin_rx.sv
module lin_rx
    import lin_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              slave,
    input  logic              rxd,
    input  logic              rd,
    input  logic [3:0]        clr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output flag_vec_t         flags
);
    localparam int BRK_TICKS = BRK_BITS * OVS;
    localparam int LOW_W     = $clog2(BRK_TICKS + 1);

    logic              meta_q, rxs_q;
    logic              active_q;
    logic [OVS_W-1:0]  sub_q;
    logic [3:0]        idx_q;
    logic              s7_q, s8_q, par_bit_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    flag_vec_t         flags_q, set_v;
    logic [LOW_W-1:0]  low_q;
    logic              maj, decide, done_stop;
    logic [3:0]        stop_idx;

    assign maj       = maj3(s7_q, s8_q, rxs_q);
    assign decide    = tick && active_q && (sub_q == OVS_W'(9));
    assign stop_idx  = par_en ? 4'd10 : 4'd9;
    assign done_stop = decide && (idx_q == stop_idx);

    always_comb begin
        set_v     = '0;
        set_v.ovr = done_stop && rvalid_q && !rd;
        set_v.frm = done_stop && !set_v.ovr && !maj;
        set_v.par = done_stop && !set_v.ovr && par_en && (par_bit_q != calc_par(sh_q, par_odd));
        set_v.brk = slave && tick && !rxs_q && (low_q == LOW_W'(BRK_TICKS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= 1'b1;
            rxs_q     <= 1'b1;
            active_q  <= 1'b0;
            sub_q     <= '0;
            idx_q     <= '0;
            s7_q      <= 1'b1;
            s8_q      <= 1'b1;
            par_bit_q <= 1'b0;
            sh_q      <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
            flags_q   <= '0;
            low_q     <= '0;
        end else begin
            meta_q <= rxd;
            rxs_q  <= meta_q;
            if (tick) begin
                if (!active_q) begin
                    if (!rxs_q) begin
                        active_q <= 1'b1;
                        sub_q    <= '0;
                        idx_q    <= '0;
                    end
                end else begin
                    sub_q <= sub_q + 1'b1;
                    if (sub_q == OVS_W'(7)) s7_q <= rxs_q;
                    if (sub_q == OVS_W'(8)) s8_q <= rxs_q;
                end
            end
            if (decide) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == 4'd0) begin
                    if (maj) active_q <= 1'b0;
                end else if (done_stop) begin
                    active_q <= 1'b0;
                end else if (idx_q <= 4'd8) begin
                    sh_q <= {maj, sh_q[DATA_W-1:1]};
                end else begin
                    par_bit_q <= maj;
                end
            end
            if (rd) rvalid_q <= 1'b0;
            if (done_stop && !set_v.ovr) begin
                rdata_q  <= sh_q;
                rvalid_q <= 1'b1;
            end
            if (rxs_q)                                        low_q <= '0;
            else if (tick && low_q != LOW_W'(BRK_TICKS))      low_q <= low_q + 1'b1;
            flags_q <= (flags_q & ~flag_vec_t'(clr)) | set_v;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;
    assign flags  = flags_q;

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rvalid_q && !rd) |=> rvalid_q); // R2
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (done_stop && rvalid_q && !rd) |=> ($stable(rdata_q) && flags_q.ovr)); // R4
    AST_BRK_MASTER: assert property (@(posedge clk) disable iff (rst)
        (!slave && !flags_q.brk) |=> !flags_q.brk); // R10
    AST_NO_SAMPLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active_q && rxs_q) |=> !active_q); // R9

endmodule

// File: rtl/lin_uart_top.sv
module lin_uart_top
    import lin_uart_pkg::*;
#(
    parameter int RLD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RLD_W-1:0] cfg_reload,
    input  logic             cfg_ext_sel,
    input  logic             ext_sclk,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_slave,
    input  logic [1:0]       cfg_brk_ext,
    input  logic [1:0]       cfg_dlm_ext,
    input  logic             tx_wr,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_brk_req,
    output logic             tx_hold_full,
    output logic             tx_busy,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic [7:0]       rx_rdata,
    output logic             rx_valid,
    input  logic [3:0]       flag_clr,
    output logic             err_parity,
    output logic             err_frame,
    output logic             err_overrun,
    output logic             brk_seen
);
    logic      tick;
    flag_vec_t flags;

    lin_baud_gen #(.RLD_W(RLD_W)) baud_i (
        .clk(clk), .rst(rst), .reload(cfg_reload),
        .ext_sel(cfg_ext_sel), .ext_clk(ext_sclk), .tick(tick)
    );

    lin_tx tx_i (
        .clk(clk), .rst(rst), .tick(tick),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .brk_ext(cfg_brk_ext), .dlm_ext(cfg_dlm_ext),
        .wr(tx_wr), .wdata(tx_wdata), .brk_req(tx_brk_req),
        .hold_full(tx_hold_full), .busy(tx_busy), .txd(txd)
    );

    lin_rx rx_i (
        .clk(clk), .rst(rst), .tick(tick),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd), .slave(cfg_slave),
        .rxd(rxd), .rd(rx_rd), .clr(flag_clr),
        .rdata(rx_rdata), .rvalid(rx_valid), .flags(flags)
    );

    assign err_parity  = flags.par;
    assign err_frame   = flags.frm;
    assign err_overrun = flags.ovr;
    assign brk_seen    = flags.brk;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (txd && !tx_hold_full && !rx_valid)); // R12

endmodule

// File: tb/lin_uart_top_tb_top.sv
module lin_uart_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RELOAD     = 1;
    localparam int BITCLK     = 16 * (RELOAD + 1);
    localparam int EXT_BITCLK = 16 * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cfg_reload = 16'(RELOAD);
    logic cfg_ext_sel = 0, ext_sclk = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_slave = 0;
    logic [1:0] cfg_brk_ext = 0, cfg_dlm_ext = 0;
    logic tx_wr = 0, tx_brk_req = 0, rx_rd = 0;
    logic [7:0] tx_wdata = 0;
    logic [3:0] flag_clr = 0;
    logic tx_hold_full, tx_busy, txd, rx_valid;
    logic err_parity, err_frame, err_overrun, brk_seen;
    logic [7:0] rx_rdata;
    logic loop_en = 1'b1, drv_rx = 1'b1;
    wire  rxd = loop_en ? txd : drv_rx;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    lin_uart_top dut_i (
        .clk(clk), .rst(rst), .cfg_reload(cfg_reload), .cfg_ext_sel(cfg_ext_sel),
        .ext_sclk(ext_sclk), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_slave(cfg_slave), .cfg_brk_ext(cfg_brk_ext), .cfg_dlm_ext(cfg_dlm_ext),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_brk_req(tx_brk_req),
        .tx_hold_full(tx_hold_full), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_valid(rx_valid), .flag_clr(flag_clr),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .brk_seen(brk_seen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (4) @(posedge clk);
            #1 ext_sclk = ~ext_sclk;
        end
    end

    function automatic bit exp_par(input bit [7:0] d, input bit odd);
        return (^d) ^ odd;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_byte(input bit [7:0] b);
        @(posedge clk); #1;
        tx_wdata = b; tx_wr = 1'b1;
        @(posedge clk); #1;
        tx_wr = 1'b0;
    endtask

    task automatic send_byte(input bit [7:0] b);
        while (tx_hold_full) @(negedge clk);
        write_byte(b);
    endtask

    task automatic wait_rx(output bit [7:0] d, output bit got);
        got = 0; d = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rx_valid) begin got = 1; d = rx_rdata; break; end
        end
        if (got) begin
            @(posedge clk); #1 rx_rd = 1'b1;
            @(posedge clk); #1 rx_rd = 1'b0;
        end
    endtask

    task automatic clear_all();
        @(posedge clk); #1 flag_clr = 4'hF; rx_rd = 1'b1;
        @(posedge clk); #1 flag_clr = 4'h0; rx_rd = 1'b0;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        @(negedge clk);
        while (txd) @(negedge clk);
        while (!txd) begin n++; @(negedge clk); end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (txd) begin n++; @(negedge clk); end
    endtask

    task automatic drive_frame(input bit [7:0] d, input bit has_par, input bit pb, input bit stopb);
        loop_en = 1'b0;
        @(posedge clk); #1 drv_rx = 1'b0;
        tick_clk(BITCLK);
        for (int i = 0; i < 8; i++) begin drv_rx = d[i]; tick_clk(BITCLK); end
        if (has_par) begin drv_rx = pb; tick_clk(BITCLK); end
        drv_rx = stopb; tick_clk(BITCLK);
        drv_rx = 1'b1; tick_clk(2 * BITCLK);
    endtask

    initial begin
        bit [7:0] d, b;
        bit got;
        int n;
        void'($urandom(32'd20240611));
        tick_clk(4);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(txd === 1'b1, "R12 txd", int'(txd), 1);
        check(!tx_hold_full && !tx_busy && !rx_valid, "R12 buffers", int'({tx_hold_full, tx_busy, rx_valid}), 0);
        check({err_parity, err_frame, err_overrun, brk_seen} === 4'b0, "R12 flags",
              int'({err_parity, err_frame, err_overrun, brk_seen}), 0);

        // R3 internal bit time: 0x01 gives a single-bit low start
        fork send_byte(8'h01); measure_low(n); join
        check(n == BITCLK, "R3 internal bit", n, BITCLK);
        wait_rx(d, got);
        check(got && d == 8'h01, "R2 loopback 0x01", int'(d), 1);

        // R2/R5 random loopback traffic
        for (int i = 0; i < 24; i++) begin
            cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
            b = 8'($urandom);
            send_byte(b);
            wait_rx(d, got);
            check(got && d == b, "R2 random byte", int'(d), int'(b));
            check(!err_parity && !err_frame, "R5 no error on clean byte",
                  int'({err_parity, err_frame}), 0);
        end
        if (b == 8'hFF) b = 8'h00;

        // R1 double buffering and write while full
        cfg_par_en = 1'b0;
        write_byte(8'hA5);
        while (tx_hold_full) @(negedge clk);
        write_byte(8'h3C);
        write_byte(8'hC3);
        @(negedge clk);
        check(tx_hold_full === 1'b1, "R1 hold full", int'(tx_hold_full), 1);
        wait_rx(d, got);
        check(got && d == 8'hA5, "R1 first byte", int'(d), 8'hA5);
        wait_rx(d, got);
        check(got && d == 8'h3C, "R1 second byte", int'(d), 8'h3C);
        tick_clk(30 * BITCLK);
        check(!rx_valid, "R1 ignored write not sent", int'(rx_valid), 0);

        // R4 overrun
        send_byte(8'h11);
        send_byte(8'h22);
        tick_clk(30 * BITCLK);
        check(rx_valid && rx_rdata == 8'h11, "R4 old byte kept", int'(rx_rdata), 8'h11);
        check(err_overrun === 1'b1, "R4 overrun flag", int'(err_overrun), 1);
        clear_all();
        @(negedge clk);
        check(!err_overrun, "R11 overrun cleared", int'(err_overrun), 0);

        // R5 parity error, R6 frame error, R11 selective clear
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        drive_frame(8'h5A, 1, ~exp_par(8'h5A, 0), 1);
        check(err_parity === 1'b1, "R5 parity error", int'(err_parity), 1);
        check(rx_valid && rx_rdata == 8'h5A, "R5 byte stored", int'(rx_rdata), 8'h5A);
        clear_all();
        cfg_par_odd = 1'b1;
        drive_frame(8'h96, 1, exp_par(8'h96, 1), 0);
        check(err_frame === 1'b1, "R6 frame error", int'(err_frame), 1);
        check(!err_parity, "R5 odd parity accepted", int'(err_parity), 0);
        @(posedge clk); #1 flag_clr = 4'b0010;
        @(posedge clk); #1 flag_clr = 4'b0000;
        @(negedge clk);
        check(!err_frame, "R11 frame cleared", int'(err_frame), 0);
        clear_all();
        cfg_par_en = 1'b0;

        // R9 short start pulse rejected
        @(posedge clk); #1 drv_rx = 1'b0;
        tick_clk(8);
        drv_rx = 1'b1;
        tick_clk(20 * BITCLK);
        check(!rx_valid && !err_frame, "R9 glitch rejected", int'({rx_valid, err_frame}), 0);

        // R10 slave: 10 bits low gives no break, 12 bits low gives one
        cfg_slave = 1'b1;
        @(posedge clk); #1 drv_rx = 1'b0;
        tick_clk(10 * BITCLK);
        drv_rx = 1'b1;
        tick_clk(3 * BITCLK);
        check(!brk_seen, "R10 short low no break", int'(brk_seen), 0);
        @(posedge clk); #1 drv_rx = 1'b0;
        tick_clk(12 * BITCLK);
        drv_rx = 1'b1;
        tick_clk(3 * BITCLK);
        check(brk_seen === 1'b1, "R10 break seen", int'(brk_seen), 1);
        clear_all(); clear_all();
        @(negedge clk);
        check(!brk_seen, "R11 break cleared", int'(brk_seen), 0);
        loop_en = 1'b1;
        tick_clk(2 * BITCLK);

        // R7/R8 break lengths, delimiter, pending byte after it
        for (int k = 0; k < 3; k++) begin
            cfg_brk_ext = (k == 0) ? 2'd3 : 2'($urandom);
            cfg_dlm_ext = (k == 0) ? 2'd0 : 2'($urandom);
            cfg_slave   = (k != 2);
            @(posedge clk); #1;
            tx_brk_req = 1'b1; tx_wr = 1'b1; tx_wdata = 8'h55;
            @(posedge clk); #1;
            tx_brk_req = 1'b0; tx_wr = 1'b0;
            measure_low(n);
            check(n == (13 + cfg_brk_ext) * BITCLK, "R7 break length", n, (13 + cfg_brk_ext) * BITCLK);
            measure_high(n);
            check(n == (1 + cfg_dlm_ext) * BITCLK, "R8 delimiter length", n, (1 + cfg_dlm_ext) * BITCLK);
            tick_clk(12 * BITCLK);
            check(brk_seen == cfg_slave, "R10 break flag by role", int'(brk_seen), int'(cfg_slave));
            clear_all(); clear_all();
        end

        // R3 external clock
        cfg_ext_sel = 1'b1;
        tick_clk(EXT_BITCLK);
        clear_all();
        fork send_byte(8'h01); measure_low(n); join
        check(n == EXT_BITCLK, "R3 external bit", n, EXT_BITCLK);
        wait_rx(d, got);
        check(got && d == 8'h01, "R3 external loopback", int'(d), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R12: actual 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule